// File: doc/BRIEF.md
# Handset Power-On Sequencer

This controller decides when the supply regulators of a battery-powered handset switch on and off. Four wake requests can start the supply rails. These are a power key that is active low, a hold line that the processor drives, a clock-alarm line and a charger-present flag. A start, once granted, brings the rails up in a fixed order. The memory rail comes first. The IO and analog rails are then actively drained for a programmable number of cycles. The core rail follows. IO and analog switch on only once a comparator reports that the core output has crossed its good level. When every wake request has gone, the rails drop one per cycle in the reverse order.

The analog side is not modelled here. Battery level, die temperature and the core rail are seen only as comparator flags. Every one of these flags, and every wake input, passes through a two-flop synchronizer. The key is also debounced. The start decision uses the following protection logic:

- A battery lockout with hysteresis blocks a start, but it is consulted only while the handset is off.
- A thermal latch with its own release threshold forces all switched rails off.
- A deep-discharge flag removes even the always-on clock rail.

The controller also provides the following outputs:

- A key status line lets the processor see a press, including a second press that requests power-down.
- A divider enable connects the battery divider while both the hold line and the oscillator request are high.

States of the controller:

- `ST_DEAD`: every rail is off.
- `ST_IDLE`: only the clock rail is on.
- `ST_MEM`: memory on.
- `ST_DISCH`: memory on, drain strobes active.
- `ST_CORE`: memory and core on.
- `ST_ON`: all rails on.
- `ST_DN_IO`, `ST_DN_ANA`, `ST_DN_CORE`: the staged power-down.

Transitions of the controller:

- Deep discharge moves any state to `ST_DEAD`. Clearing it moves `ST_DEAD` to `ST_IDLE`.
- The thermal latch moves any other state to `ST_IDLE`.
- A granted wake moves `ST_IDLE` to `ST_MEM`, and one cycle later to `ST_DISCH`.
- When the delay count expires, `ST_DISCH` moves to `ST_CORE`.
- Core good moves `ST_CORE` to `ST_ON`.
- Loss of all wake requests moves `ST_ON` to `ST_DN_IO`, then `ST_DN_ANA`, then `ST_DN_CORE`, then `ST_IDLE`.
- Loss of all wake requests during start-up moves `ST_MEM` or `ST_DISCH` to `ST_DN_CORE`, and `ST_CORE` to `ST_DN_ANA`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Any one of the four wake requests starts the sequence from idle when the lockout is clear: key low, hold high, alarm high or charger flag high.
- R2: Memory enables first. The IO and analog drain strobes are then high for exactly PD_CYCLES cycles, during which IO and analog stay off. Core enables in the cycle after the last strobe, PD_CYCLES+1 cycles after memory.
- R3: IO and analog enable only after the synchronized core-good flag has been seen. After the flag rises they enable on the third clock edge.
- R4: Out of reset the battery lockout is active and blocks any start. Once the upper battery flag has been high, starts are allowed until the lower battery flag goes low.
- R5: The lockout is ignored while rails are up: a low battery flag does not drop them. A charger wake is refused while the lockout is active.
- R6: The deep-discharge flag turns off every rail including the clock rail. After it clears, the clock rail returns.
- R7: The over-temperature flag disables every rail except the clock rail. The rails stay off, whatever the wake inputs, until the cool flag is high.
- R8: With the key as the only wake source, rails stay on only while the key is held. If the hold line is high the rails stay on after key release. key_stat_n is low while the debounced key is pressed, including a second press while on.
- R9: A key press shorter than DB_CYCLES cycles has no effect on key_stat_n or on the rails.
- R10: osc_rail_en follows osc_req only while fully on. div_en is high exactly when the synchronized hold and osc_req are both high.
- R11: When every wake request is gone, IO drops first, then analog, then core, then memory, one rail per cycle, ending with only the clock rail on.
- R12: After reset only rtc_en is high, and key_stat_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_n | input | 1 | Power key, low when pressed |
| hold_in | input | 1 | Processor hold-on request |
| alarm_in | input | 1 | Clock-alarm wake |
| chg_det | input | 1 | Charger present flag |
| bat_hi | input | 1 | Battery above upper lockout level |
| bat_lo | input | 1 | Battery above lower lockout level |
| deep_low | input | 1 | Battery deeply discharged |
| temp_hot | input | 1 | Die above shutdown temperature |
| temp_cool | input | 1 | Die below release temperature |
| core_ok | input | 1 | Core rail above its good level |
| osc_req | input | 1 | Oscillator rail request |
| rtc_en | output | 1 | Clock rail enable |
| mem_en | output | 1 | Memory rail enable |
| core_en | output | 1 | Core rail enable |
| io_en | output | 1 | IO rail enable |
| ana_en | output | 1 | Analog rail enable |
| osc_rail_en | output | 1 | Oscillator rail enable |
| io_dis | output | 1 | IO rail drain strobe |
| ana_dis | output | 1 | Analog rail drain strobe |
| key_stat_n | output | 1 | Debounced key status, low when pressed |
| div_en | output | 1 | Battery divider enable |

## Verification
The bench counts the exact drain window and the memory-to-core gap. A design off by one in its delay counter shows a wrong strobe count. It also holds core-good low to catch IO rising early.

It walks the lockout hysteresis in both directions and tests a charger wake under lockout, which an unguarded design would honour. It also checks that a sagging battery does not drop live rails.

It sweeps all four wake sources. It checks the power-down order cycle by cycle, so a swapped or merged step shows up. A key pulse one cycle shorter than the debounce window is sent to catch a debounce that is too short.

The thermal test holds the die between the two thresholds to catch a latch without hysteresis. The deep-discharge test looks for a clock rail left on.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_DEAD,
        ST_IDLE,
        ST_MEM,
        ST_DISCH,
        ST_CORE,
        ST_ON,
        ST_DN_IO,
        ST_DN_ANA,
        ST_DN_CORE
    } seq_state_e;

    typedef struct packed {
        logic rtc;
        logic mem;
        logic core;
        logic io;
        logic ana;
    } rail_en_t;

    localparam int unsigned IX_KEY   = 0;
    localparam int unsigned IX_HOLD  = 1;
    localparam int unsigned IX_ALARM = 2;
    localparam int unsigned IX_CHG   = 3;
    localparam int unsigned IX_BHI   = 4;
    localparam int unsigned IX_BLO   = 5;
    localparam int unsigned IX_DEEP  = 6;
    localparam int unsigned IX_HOT   = 7;
    localparam int unsigned IX_COOL  = 8;
    localparam int unsigned IX_CORE  = 9;
    localparam int unsigned IX_OSC   = 10;
    localparam int unsigned N_ASYNC  = 11;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/pwr_debounce.sv
module pwr_debounce #(
    parameter int unsigned DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic stable
);
    localparam int unsigned CW = $clog2(DB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            stable <= 1'b0;
        end else if (raw == stable) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            stable <= raw;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: the filtered value only moves when the raw value has disagreed with it
    a_r9_filtered_moves_on_disagree: assert property (@(posedge clk) disable iff (!rst_n)
        (stable != $past(stable)) |-> ($past(raw) != $past(stable)));
endmodule

// File: rtl/pwr_lockout.sv
module pwr_lockout (
    input  logic clk,
    input  logic rst_n,
    input  logic bat_hi,
    input  logic bat_lo,
    input  logic hot,
    input  logic cool,
    output logic uv_ok,
    output logic therm_lock
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_ok      <= 1'b0;
            therm_lock <= 1'b0;
        end else begin
            if (bat_hi)
                uv_ok <= 1'b1;
            else if (!bat_lo)
                uv_ok <= 1'b0;

            if (hot)
                therm_lock <= 1'b1;
            else if (cool)
                therm_lock <= 1'b0;
        end
    end

    // R4: the lockout clears only after the upper battery flag was seen
    a_r4_clear_needs_upper: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_ok) |-> $past(bat_hi));

    // R7: the thermal latch cannot release while the die is still hot
    a_r7_hot_holds_latch: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> therm_lock);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int unsigned PD_CYCLES = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wake_key,
    input  logic     hold,
    input  logic     alarm,
    input  logic     chg,
    input  logic     uv_ok,
    input  logic     therm_lock,
    input  logic     deep,
    input  logic     core_ok,
    input  logic     osc_req,
    output rail_en_t rails,
    output logic     osc_rail,
    output logic     io_dis,
    output logic     ana_dis
);
    localparam int unsigned PW = $clog2(PD_CYCLES + 1);
    localparam logic [PW-1:0] PD_LAST = PW'(PD_CYCLES - 1);

    seq_state_e    state, nxt;
    logic [PW-1:0] pd_cnt;
    logic          wake_any;

    assign wake_any = wake_key | hold | alarm | chg;

    always_comb begin
        nxt = state;
        if (deep) begin
            nxt = ST_DEAD;
        end else if (therm_lock) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_DEAD:    nxt = ST_IDLE;
                ST_IDLE:    nxt = (wake_any && uv_ok) ? ST_MEM : ST_IDLE;
                ST_MEM:     nxt = wake_any ? ST_DISCH : ST_DN_CORE;
                ST_DISCH:   nxt = !wake_any ? ST_DN_CORE :
                                  (pd_cnt == PD_LAST) ? ST_CORE : ST_DISCH;
                ST_CORE:    nxt = !wake_any ? ST_DN_ANA : (core_ok ? ST_ON : ST_CORE);
                ST_ON:      nxt = wake_any ? ST_ON : ST_DN_IO;
                ST_DN_IO:   nxt = ST_DN_ANA;
                ST_DN_ANA:  nxt = ST_DN_CORE;
                ST_DN_CORE: nxt = ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pd_cnt <= '0;
        end else begin
            state  <= nxt;
            pd_cnt <= (state == ST_DISCH && nxt == ST_DISCH) ? pd_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        rails   = '0;
        io_dis  = 1'b0;
        ana_dis = 1'b0;
        unique case (state)
            ST_DEAD:    rails = '0;
            ST_IDLE:    rails.rtc = 1'b1;
            ST_MEM:     rails = '{rtc: 1'b1, mem: 1'b1, core: 1'b0, io: 1'b0, ana: 1'b0};
            ST_DISCH: begin
                rails   = '{rtc: 1'b1, mem: 1'b1, core: 1'b0, io: 1'b0, ana: 1'b0};
                io_dis  = 1'b1;
                ana_dis = 1'b1;
            end
            ST_CORE:    rails = '{rtc: 1'b1, mem: 1'b1, core: 1'b1, io: 1'b0, ana: 1'b0};
            ST_ON:      rails = '{rtc: 1'b1, mem: 1'b1, core: 1'b1, io: 1'b1, ana: 1'b1};
            ST_DN_IO:   rails = '{rtc: 1'b1, mem: 1'b1, core: 1'b1, io: 1'b0, ana: 1'b1};
            ST_DN_ANA:  rails = '{rtc: 1'b1, mem: 1'b1, core: 1'b1, io: 1'b0, ana: 1'b0};
            ST_DN_CORE: rails = '{rtc: 1'b1, mem: 1'b1, core: 1'b0, io: 1'b0, ana: 1'b0};
            default:    rails = '0;
        endcase
    end

    assign osc_rail = (state == ST_ON) && osc_req;

    // R2: core never runs without memory, and it rises only out of the drain window
    a_r2_core_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
        rails.core |-> rails.mem);
    a_r2_core_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rails.core) |-> $past(io_dis));

    // R3: IO and analog rise only after core was on and reported good
    a_r3_io_after_core_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rails.io) |-> ($past(core_ok) && $past(rails.core)));

    // R2: strobes and the rails they drain are exclusive
    a_r2_drain_excludes_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (io_dis || ana_dis) |-> (!rails.io && !rails.ana));

    // R4: a start from idle requires a clear lockout
    a_r4_start_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rails.mem) |-> $past(uv_ok));

    // R6: deep discharge removes the clock rail
    a_r6_deep_kills_rtc: assert property (@(posedge clk) disable iff (!rst_n)
        deep |=> !rails.rtc);

    // R7: thermal latch removes every switched rail
    a_r7_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        therm_lock |=> (!rails.mem && !rails.core && !rails.io && !rails.ana));

    // R11: in an orderly power-down core drops after IO and analog, memory after core
    a_r11_core_after_io: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rails.core) && !$past(deep) && !$past(therm_lock))
            |-> (!$past(rails.io) && !$past(rails.ana)));
    a_r11_mem_after_core: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rails.mem) && !$past(deep) && !$past(therm_lock)) |-> !$past(rails.core));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned PD_CYCLES = 64,
    parameter int unsigned DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n,
    input  logic hold_in,
    input  logic alarm_in,
    input  logic chg_det,
    input  logic bat_hi,
    input  logic bat_lo,
    input  logic deep_low,
    input  logic temp_hot,
    input  logic temp_cool,
    input  logic core_ok,
    input  logic osc_req,
    output logic rtc_en,
    output logic mem_en,
    output logic core_en,
    output logic io_en,
    output logic ana_en,
    output logic osc_rail_en,
    output logic io_dis,
    output logic ana_dis,
    output logic key_stat_n,
    output logic div_en
);
    logic [N_ASYNC-1:0] raw_in, syn;
    logic               key_db, uv_ok, therm_lock;
    rail_en_t           rails;

    always_comb begin
        raw_in           = '0;
        raw_in[IX_KEY]   = ~key_n;
        raw_in[IX_HOLD]  = hold_in;
        raw_in[IX_ALARM] = alarm_in;
        raw_in[IX_CHG]   = chg_det;
        raw_in[IX_BHI]   = bat_hi;
        raw_in[IX_BLO]   = bat_lo;
        raw_in[IX_DEEP]  = deep_low;
        raw_in[IX_HOT]   = temp_hot;
        raw_in[IX_COOL]  = temp_cool;
        raw_in[IX_CORE]  = core_ok;
        raw_in[IX_OSC]   = osc_req;
    end

    pwr_sync #(.W(N_ASYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    pwr_debounce #(.DB_CYCLES(DB_CYCLES)) u_key_db (
        .clk(clk), .rst_n(rst_n), .raw(syn[IX_KEY]), .stable(key_db)
    );

    pwr_lockout u_lock (
        .clk(clk), .rst_n(rst_n),
        .bat_hi(syn[IX_BHI]), .bat_lo(syn[IX_BLO]),
        .hot(syn[IX_HOT]), .cool(syn[IX_COOL]),
        .uv_ok(uv_ok), .therm_lock(therm_lock)
    );

    pwr_seq_fsm #(.PD_CYCLES(PD_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wake_key(key_db), .hold(syn[IX_HOLD]), .alarm(syn[IX_ALARM]),
        .chg(syn[IX_CHG]), .uv_ok(uv_ok), .therm_lock(therm_lock),
        .deep(syn[IX_DEEP]), .core_ok(syn[IX_CORE]), .osc_req(syn[IX_OSC]),
        .rails(rails), .osc_rail(osc_rail_en), .io_dis(io_dis), .ana_dis(ana_dis)
    );

    assign rtc_en     = rails.rtc;
    assign mem_en     = rails.mem;
    assign core_en    = rails.core;
    assign io_en      = rails.io;
    assign ana_en     = rails.ana;
    assign key_stat_n = ~key_db;
    assign div_en     = syn[IX_HOLD] & syn[IX_OSC];

    // R10: the oscillator rail is never on without the full rail set
    a_r10_osc_only_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        osc_rail_en |-> (io_en && core_en));
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
    localparam int PD = 5;
    localparam int DB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_n = 1'b1, hold_in = 1'b0, alarm_in = 1'b0, chg_det = 1'b0;
    logic bat_hi = 1'b0, bat_lo = 1'b1, deep_low = 1'b0;
    logic temp_hot = 1'b0, temp_cool = 1'b1, core_ok = 1'b0, osc_req = 1'b0;
    logic rtc_en, mem_en, core_en, io_en, ana_en, osc_rail_en;
    logic io_dis, ana_dis, key_stat_n, div_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_seq_ctrl #(.PD_CYCLES(PD), .DB_CYCLES(DB)) dut (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .hold_in(hold_in),
        .alarm_in(alarm_in), .chg_det(chg_det), .bat_hi(bat_hi), .bat_lo(bat_lo),
        .deep_low(deep_low), .temp_hot(temp_hot), .temp_cool(temp_cool),
        .core_ok(core_ok), .osc_req(osc_req), .rtc_en(rtc_en), .mem_en(mem_en),
        .core_en(core_en), .io_en(io_en), .ana_en(ana_en), .osc_rail_en(osc_rail_en),
        .io_dis(io_dis), .ana_dis(ana_dis), .key_stat_n(key_stat_n), .div_en(div_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rv();
        return {rtc_en, mem_en, core_en, io_en, ana_en};
    endfunction

    task automatic wait_up(input int lim);
        for (int i = 0; i < lim && !io_en; i++) tick(1);
    endtask

    task automatic clear_lockout();
        bat_lo = 1'b1;
        bat_hi = 1'b1;
        tick(6);
        bat_hi = 1'b0;
        tick(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, dis, c;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12 reset state: rails vector {rtc,mem,core,io,ana}
        chk("R12 rails after reset", rv(), 5'b10000);
        chk("R12 key status after reset", key_stat_n, 1);

        // R4 lockout active from reset
        hold_in = 1'b1;
        tick(20);
        chk("R4 start refused under lockout", mem_en, 0);

        // R4 clear via upper flag, then R2 ordering
        bat_hi = 1'b1;
        tick(1);
        bat_hi = 1'b0;
        for (int i = 0; i < 50 && !mem_en; i++) tick(1);
        chk("R4 start after upper flag", mem_en, 1);
        n = 0;
        dis = 0;
        for (int i = 0; i < 60 && !core_en; i++) begin
            tick(1);
            n++;
            if (io_dis && ana_dis) dis++;
            if (io_en || ana_en) chk("R2 io/ana off during drain", io_en | ana_en, 0);
        end
        chk("R2 drain strobe cycles", dis, PD);
        chk("R2 mem-to-core cycles", n, PD + 1);

        // R3 gated by core good
        tick(10);
        chk("R3 io waits for core good", io_en | ana_en, 0);
        core_ok = 1'b1;
        n = 0;
        for (int i = 0; i < 20 && !io_en; i++) begin
            tick(1);
            n++;
        end
        chk("R3 io latency after core good", n, 3);
        chk("R3 analog with io", ana_en, 1);

        // R5 lockout ignored while on
        bat_lo = 1'b0;
        tick(10);
        chk("R5 rails kept on low battery", rv(), 5'b11111);

        // R10 oscillator and divider
        chk("R10 osc rail off without request", osc_rail_en, 0);
        osc_req = 1'b1;
        tick(4);
        chk("R10 osc rail follows request", osc_rail_en, 1);
        chk("R10 divider hold&osc", div_en, 1);
        osc_req = 1'b0;
        tick(4);
        chk("R10 osc rail drops", osc_rail_en, 0);
        chk("R10 divider drops", div_en, 0);

        // R11 reverse-order power-down
        hold_in = 1'b0;
        for (int i = 0; i < 20 && io_en; i++) tick(1);
        chk("R11 step io off", rv(), 5'b11101);
        tick(1);
        chk("R11 step analog off", rv(), 5'b11100);
        tick(1);
        chk("R11 step core off", rv(), 5'b11000);
        tick(1);
        chk("R11 step memory off", rv(), 5'b10000);

        // R5 charger wake refused under lockout (bat_lo low while off)
        tick(5);
        chg_det = 1'b1;
        tick(20);
        chk("R5 charger wake blocked", mem_en, 0);
        chg_det = 1'b0;
        clear_lockout();

        // R1 sweep over four wake sources, R8 key status
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: key_n = 1'b0;
                1: hold_in = 1'b1;
                2: alarm_in = 1'b1;
                default: chg_det = 1'b1;
            endcase
            wait_up(60);
            chk($sformatf("R1 wake source %0d rails on", s), rv(), 5'b11111);
            chk($sformatf("R8 key status source %0d", s), key_stat_n, (s == 0) ? 0 : 1);
            key_n = 1'b1;
            hold_in = 1'b0;
            alarm_in = 1'b0;
            chg_det = 1'b0;
            tick(20);
            chk($sformatf("R1 wake source %0d released", s), rv(), 5'b10000);
        end

        // R8 key then hold keeps rails; second press seen
        key_n = 1'b0;
        wait_up(60);
        hold_in = 1'b1;
        tick(4);
        key_n = 1'b1;
        tick(20);
        chk("R8 hold keeps rails after key release", rv(), 5'b11111);
        chk("R8 key status released", key_stat_n, 1);
        key_n = 1'b0;
        tick(10);
        chk("R8 second press seen", key_stat_n, 0);
        key_n = 1'b1;
        hold_in = 1'b0;
        tick(20);
        chk("R8 off after hold drop", rv(), 5'b10000);

        // R9 short key pulse ignored
        c = 0;
        key_n = 1'b0;
        tick(DB - 1);
        key_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (!key_stat_n || mem_en) c++;
        end
        chk("R9 short pulse ignored", c, 0);

        // R7 thermal latch with hysteresis
        hold_in = 1'b1;
        wait_up(60);
        temp_hot = 1'b1;
        temp_cool = 1'b0;
        tick(6);
        chk("R7 hot keeps only rtc", rv(), 5'b10000);
        temp_hot = 1'b0;
        tick(20);
        chk("R7 stays off between thresholds", rv(), 5'b10000);
        temp_cool = 1'b1;
        wait_up(60);
        chk("R7 restarts when cool", rv(), 5'b11111);

        // R6 deep discharge
        deep_low = 1'b1;
        tick(6);
        chk("R6 deep removes all rails", rv(), 5'b00000);
        deep_low = 1'b0;
        tick(4);
        chk("R6 rtc back after deep clears", rtc_en, 1);
        hold_in = 1'b0;
        tick(20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule